// File: doc/BRIEF.md
# Dual-Edge Manchester Word Receiver

This block turns a 1 Mbit/s Manchester II serial stream, as delivered by a bus transceiver, into 20-bit-time words. Each word opens with a sync of three bit times that changes level once at its middle. Sixteen data bits follow, most significant bit first, and one odd-parity bit closes the word. The receiver runs from a system clock of 10, 12, 16 or 20 MHz, selected at run time by a two-bit input. All bit-timing windows are derived from that selection.

The receive lines are captured on both clock edges, so the decoder sees two samples per clock and places every zero crossing to half a clock period. A mode input chooses between a complementary line pair and a single data line, such as the output of an optical receiver. In pair mode, equal levels on both lines mean the bus is quiet.

Each accepted word produces a one-clock valid strobe together with the sixteen data bits and a flag that tells command/status sync from data sync. A malformed word produces a one-clock error strobe instead.

Top module: `manch_rx`

## Requirements
- R1: `clk_sel` values 0, 1, 2, 3 select 10, 12, 16, 20 system clocks per bit time. Words sent at the selected rate are decoded at every setting. A word sent at a rate other than the selected one yields neither valid nor error strobe.
- R2: Both receive lines are sampled on both clock edges. A mid-bit crossing displaced by one half clock period from its nominal place still decodes correctly. A mid-bit crossing is accepted within plus or minus a quarter bit of its nominal place.
- R3: A sync that is high for 1.5 bit times and then low for 1.5 bit times sets `cmd_sync_o` to 1. The opposite order sets it to 0. Each bit is sent high-then-low for a 1 and low-then-high for a 0. The first data bit lands in `word_o[15]`.
- R4: If any data or parity bit lacks a mid-bit crossing inside its window, `word_err_o` pulses for one clock and no valid strobe is issued for that word.
- R5: The count of ones over the 16 data bits plus the parity bit must be odd. If it is even, `word_err_o` pulses and no valid strobe is issued.
- R6: `word_vld_o` is high for exactly one clock per good word and is never high together with `word_err_o`. `word_o` changes only with a valid strobe.
- R7: In pair mode, `rx_pos` equal to `rx_neg` for more than one bit time inside a word is treated as bus idle. `word_err_o` pulses, the decoder returns to sync hunt, and the next well-formed word decodes.
- R8: With `single_end` = 1, only `rx_pos` carries data and `rx_neg` is ignored, even when it equals `rx_pos` throughout. In pair mode that same line state reads as idle, and no word is decoded.
- R9: Two words sent back to back with no gap both decode. This holds when the next sync's first half continues the level of the parity bit's second half.
- R10: While `rst` is high, and afterwards on an idle line, `word_o`, `cmd_sync_o`, `word_vld_o` and `word_err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 10/12/16/20 MHz as selected |
| rst | input | 1 | Synchronous active-high reset |
| clk_sel | input | 2 | Clock-rate select: 0=10, 1=12, 2=16, 3=20 MHz |
| single_end | input | 1 | 1: one-line reception on rx_pos; 0: line pair |
| rx_pos | input | 1 | Receive line (true side) |
| rx_neg | input | 1 | Receive line (complement side), unused in one-line mode |
| word_o | output | 16 | Last good data word, first received bit in bit 15 |
| cmd_sync_o | output | 1 | 1 when the last good word had command/status sync |
| word_vld_o | output | 1 | One-clock strobe for a good word |
| word_err_o | output | 1 | One-clock strobe for a malformed word |

## Verification
The hardest situation to reach from the ports is a zero crossing that falls between two rising edges, on top of back-to-back words whose sync continues the line level left by the previous parity bit. Both the half-clock sampling path and the boundary re-anchoring after a word are needed there. The bench drives the lines with delays counted in half clock periods, so crossings land alternately after rising and falling edges. One directed case pushes a single mid-bit crossing one half period late. Another sends a command word followed at once by a data word, and the first word's data is chosen so that its parity bit ends low, which leaves the line low into the data sync.

// File: rtl/manch_pkg.sv
package manch_pkg;
  localparam int unsigned CNT_W = 8;          // elapsed-sample counter width
  localparam int unsigned DW    = 16;         // data bits per word
  localparam int unsigned FW    = DW + 1;     // data plus parity
  localparam int unsigned BIT_W = $clog2(FW + 1);
  localparam int unsigned SEL_W = 2;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_DATA = 2'd1,
    ST_TAIL = 2'd2
  } phase_e;

  // all limits in half-clock samples, elapsed since the last anchor
  typedef struct packed {
    logic [CNT_W-1:0] sync_lo;
    logic [CNT_W-1:0] sync_hi;
    logic [CNT_W-1:0] first_lo;
    logic [CNT_W-1:0] first_hi;
    logic [CNT_W-1:0] bit_lo;
    logic [CNT_W-1:0] bit_hi;
    logic [CNT_W-1:0] idle_max;
    logic [CNT_W-1:0] tail;
  } win_t;

  typedef struct packed {
    phase_e           ph;
    logic             lvl;
    logic             cmd;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] icnt;
    logic [BIT_W-1:0] nbit;
    logic [FW-1:0]    sh;
    logic             ok;
    logic             bad;
  } dec_t;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction

  function automatic int unsigned clk_per_bit(input logic [SEL_W-1:0] sel);
    case (sel)
      2'd0:    return 10;
      2'd1:    return 12;
      2'd2:    return 16;
      default: return 20;
    endcase
  endfunction
endpackage

// File: rtl/manch_sampler.sv
module manch_sampler
  import manch_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       single_end,
  input  logic       rx_pos,
  input  logic       rx_neg,
  output logic [1:0] smp,   // [0] = falling-edge sample, [1] = rising-edge sample
  output logic [1:0] idl
);
  logic fall_p, fall_n;

  always_ff @(negedge clk) begin
    if (rst) begin
      fall_p <= 1'b0;
      fall_n <= 1'b0;
    end else begin
      fall_p <= rx_pos;
      fall_n <= rx_neg;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      smp <= '0;
      idl <= '0;
    end else begin
      smp <= {rx_pos, fall_p};
      idl <= {!single_end && (rx_pos == rx_neg), !single_end && (fall_p == fall_n)};
    end
  end

  // R8: one-line mode never reports idle
  a_r8_no_idle_single: assert property (@(posedge clk) disable iff (rst)
    single_end |=> (idl == 2'b00));
endmodule

// File: rtl/manch_timing.sv
module manch_timing
  import manch_pkg::*;
(
  input  logic             clk,
  input  logic [SEL_W-1:0] sel,
  output win_t             win
);
  int unsigned f;

  always_comb f = clk_per_bit(sel);   // clocks per bit; 2*f samples per bit

  always_ff @(posedge clk) begin
    win.sync_lo  <= CNT_W'((5 * f) / 2);
    win.sync_hi  <= CNT_W'((7 * f) / 2);
    win.first_lo <= CNT_W'((7 * f) / 2);
    win.first_hi <= CNT_W'((9 * f) / 2);
    win.bit_lo   <= CNT_W'((3 * f) / 2);
    win.bit_hi   <= CNT_W'((5 * f) / 2);
    win.idle_max <= CNT_W'(2 * f);
    win.tail     <= CNT_W'(f);
  end
endmodule

// File: rtl/manch_core.sv
module manch_core
  import manch_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    smp,
  input  logic [1:0]    idl,
  input  win_t          win,
  output logic [DW-1:0] word_o,
  output logic          cmd_o,
  output logic          vld_o,
  output logic          err_o
);
  function automatic dec_t step(input dec_t c, input logic s, input logic idle, input win_t w);
    dec_t             n;
    logic             tr;
    logic [CNT_W-1:0] el;
    logic [FW-1:0]    shn;
    n      = c;
    n.ok   = 1'b0;
    n.bad  = 1'b0;
    n.lvl  = s;
    tr     = s ^ c.lvl;
    el     = sat_inc(c.cnt);
    n.cnt  = el;
    n.icnt = idle ? sat_inc(c.icnt) : '0;
    shn    = {c.sh[FW-2:0], ~s};
    unique case (c.ph)
      ST_HUNT: begin
        if (idle) n.cnt = '0;
        else if (tr) begin
          n.cnt = '0;
          if (el >= w.sync_lo && el <= w.sync_hi) begin
            n.ph   = ST_DATA;
            n.cmd  = c.lvl;
            n.nbit = '0;
          end
        end
      end
      ST_DATA: begin
        if (idle && n.icnt > w.idle_max) begin
          n.bad = 1'b1;
          n.ph  = ST_HUNT;
          n.cnt = '0;
        end else if (tr && el >= ((c.nbit == '0) ? w.first_lo : w.bit_lo)) begin
          n.sh   = shn;
          n.cnt  = '0;
          n.nbit = c.nbit + 1'b1;
          if (c.nbit == BIT_W'(FW - 1)) begin
            n.ph  = ST_TAIL;
            n.ok  = ^shn;
            n.bad = ~^shn;
          end
        end else if (el > ((c.nbit == '0) ? w.first_hi : w.bit_hi)) begin
          n.bad = 1'b1;
          n.ph  = ST_HUNT;
          n.cnt = '0;
        end
      end
      ST_TAIL: begin
        if (el >= w.tail) begin
          n.ph  = ST_HUNT;
          n.cnt = '0;
        end
      end
      default: n.ph = ST_HUNT;
    endcase
    return n;
  endfunction

  dec_t st_q, st_a, st_b;
  logic par_q;

  always_comb begin
    st_a = step(st_q, smp[0], idl[0], win);
    st_b = step(st_a, smp[1], idl[1], win);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= '0;
      word_o <= '0;
      par_q  <= 1'b0;
      cmd_o  <= 1'b0;
      vld_o  <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      st_q  <= st_b;
      vld_o <= st_a.ok | st_b.ok;
      err_o <= st_a.bad | st_b.bad;
      if (st_a.ok) begin
        {word_o, par_q} <= st_a.sh;
        cmd_o           <= st_a.cmd;
      end else if (st_b.ok) begin
        {word_o, par_q} <= st_b.sh;
        cmd_o           <= st_b.cmd;
      end
    end
  end

  // R6: valid is a single-clock strobe
  a_r6_one_cycle: assert property (@(posedge clk) disable iff (rst) vld_o |=> !vld_o);
  // R6: valid and error never coincide
  a_r6_exclusive: assert property (@(posedge clk) disable iff (rst) !(vld_o && err_o));
  // R6: word output only moves with a valid strobe
  a_r6_hold: assert property (@(posedge clk) disable iff (rst) !vld_o |-> $stable(word_o));
  // R5: every accepted word carries odd parity
  a_r5_odd: assert property (@(posedge clk) disable iff (rst) vld_o |-> ^{word_o, par_q});
  // R4: error is a single-clock strobe
  a_r4_err_pulse: assert property (@(posedge clk) disable iff (rst) err_o |=> !err_o);
endmodule

// File: rtl/manch_rx.sv
module manch_rx
  import manch_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] clk_sel,
  input  logic             single_end,
  input  logic             rx_pos,
  input  logic             rx_neg,
  output logic [DW-1:0]    word_o,
  output logic             cmd_sync_o,
  output logic             word_vld_o,
  output logic             word_err_o
);
  logic [1:0] smp, idl;
  win_t       win;

  manch_sampler u_smp (
    .clk(clk), .rst(rst), .single_end(single_end),
    .rx_pos(rx_pos), .rx_neg(rx_neg), .smp(smp), .idl(idl)
  );

  manch_timing u_tim (
    .clk(clk), .sel(clk_sel), .win(win)
  );

  manch_core u_core (
    .clk(clk), .rst(rst), .smp(smp), .idl(idl), .win(win),
    .word_o(word_o), .cmd_o(cmd_sync_o), .vld_o(word_vld_o), .err_o(word_err_o)
  );
endmodule

// File: tb/manch_rx_test.sv
`timescale 1ns/1ps
module manch_rx_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  clk_sel = 2'd0;
  logic        single_end = 1'b0;
  logic        rx_pos = 1'b0;
  logic        rx_neg = 1'b0;
  logic [15:0] word_o;
  logic        cmd_sync_o, word_vld_o, word_err_o;

  manch_rx uut (
    .clk(clk), .rst(rst), .clk_sel(clk_sel), .single_end(single_end),
    .rx_pos(rx_pos), .rx_neg(rx_neg), .word_o(word_o),
    .cmd_sync_o(cmd_sync_o), .word_vld_o(word_vld_o), .word_err_o(word_err_o)
  );

  always #4 clk = ~clk;   // 125 MHz

  int checks = 0, fails = 0;
  int vld_cnt = 0, err_cnt = 0, dbl_cnt = 0;
  logic [15:0] cap_w [4];
  logic        cap_c [4];
  logic        prev_v = 1'b0;
  logic        neg_eq = 1'b0;
  logic [15:0] last_good = 16'h0000;

  // {sel, cmd, parity_flip, data}
  localparam logic [19:0] VEC [8] = '{
    {2'd0, 1'b1, 1'b0, 16'h0000},
    {2'd0, 1'b0, 1'b0, 16'hFFFF},
    {2'd1, 1'b1, 1'b0, 16'hA5A5},
    {2'd1, 1'b0, 1'b1, 16'h1234},
    {2'd2, 1'b0, 1'b0, 16'h8001},
    {2'd2, 1'b1, 1'b0, 16'h5A3C},
    {2'd3, 1'b1, 1'b0, 16'hFFFE},
    {2'd3, 1'b0, 1'b1, 16'h0F0F}
  };

  always @(negedge clk) begin
    if (!rst) begin
      if (word_vld_o) begin
        if (vld_cnt < 4) begin
          cap_w[vld_cnt] = word_o;
          cap_c[vld_cnt] = cmd_sync_o;
        end
        vld_cnt++;
        if (prev_v) dbl_cnt++;
      end
      if (word_err_o) err_cnt++;
    end
    prev_v = word_vld_o;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int fsel(input logic [1:0] s);
    case (s)
      2'd0: return 10;
      2'd1: return 12;
      2'd2: return 16;
      default: return 20;
    endcase
  endfunction

  task automatic clr();
    vld_cnt = 0;
    err_cnt = 0;
  endtask

  task automatic hs(input logic l, input int n);   // n half-clock samples
    rx_pos = l;
    rx_neg = neg_eq ? l : ~l;
    #(4 * n);
  endtask

  task automatic gap(input int n);
    rx_pos = 1'b0;
    rx_neg = 1'b0;
    #(4 * n);
  endtask

  task automatic send(input int f, input logic cmd, input logic [15:0] d, input logic flip,
                      input int skew_bit, input int skew, input int miss_bit, input int eq_bit);
    logic v, par, old_eq;
    old_eq = neg_eq;
    par = ~(^d) ^ flip;
    hs(cmd, 3 * f);
    hs(~cmd, 3 * f);
    for (int b = 0; b < 17; b++) begin
      if (b == eq_bit) neg_eq = 1'b1;
      v = (b < 16) ? d[15 - b] : par;
      if (b == miss_bit) hs(v, 2 * f);
      else if (b == skew_bit) begin
        hs(v, f + skew);
        hs(~v, f - skew);
      end else begin
        hs(v, f);
        hs(~v, f);
      end
    end
    neg_eq = old_eq;
  endtask

  task automatic one_word(input logic [1:0] sel, input logic cmd, input logic [15:0] d,
                          input logic flip, input int f_tx);
    clk_sel = sel;
    clr();
    gap(8 * f_tx);
    send(f_tx, cmd, d, flip, -1, 0, -1, 99);
    gap(6 * f_tx);
  endtask

  logic [19:0] v;

  initial begin
    repeat (4) @(posedge clk);
    #1;
    chk(word_vld_o == 0 && word_err_o == 0, "R10 strobes in reset", {word_vld_o, word_err_o}, 0);
    chk(word_o == 0 && cmd_sync_o == 0, "R10 word in reset", {cmd_sync_o, word_o}, 0);
    rst = 1'b0;
    repeat (20) @(posedge clk);
    #1;
    chk(word_o == 0 && cmd_sync_o == 0 && vld_cnt == 0 && err_cnt == 0,
        "R10 idle after reset", {vld_cnt, err_cnt}, 0);

    // table walk: R1 rates, R3 sync/bit order, R5 parity, R6 hold
    for (int i = 0; i < 8; i++) begin
      v = VEC[i];
      one_word(v[19:18], v[17], v[15:0], v[16], fsel(v[19:18]));
      if (v[16]) begin
        chk(vld_cnt == 0 && err_cnt == 1, "R5 bad parity strobes", {vld_cnt, err_cnt}, 1);
        chk(word_o == last_good, "R6 word held after error", word_o, last_good);
      end else begin
        chk(vld_cnt == 1 && err_cnt == 0, "R1 word decoded at rate", {vld_cnt, err_cnt}, 32'h10000);
        chk(cap_w[0] == v[15:0], "R3 data bits", cap_w[0], v[15:0]);
        chk(cap_c[0] == v[17], "R3 sync type", cap_c[0], v[17]);
        last_good = v[15:0];
      end
    end

    // R1: rate mismatch -> nothing
    one_word(2'd3, 1'b1, 16'h4321, 1'b0, 10);
    chk(vld_cnt == 0 && err_cnt == 0, "R1 mismatched rate ignored", {vld_cnt, err_cnt}, 0);

    // R2: mid-bit crossing one half period late
    clk_sel = 2'd0; clr(); gap(80);
    send(10, 1'b1, 16'h6C93, 1'b0, 5, 1, -1, 99); gap(60);
    chk(vld_cnt == 1 && cap_w[0] == 16'h6C93, "R2 half-period skew", cap_w[0], 16'h6C93);

    // R4: crossing outside window
    clr(); gap(80);
    send(10, 1'b0, 16'h2222, 1'b0, 3, 7, -1, 99); gap(60);
    chk(vld_cnt == 0 && err_cnt == 1, "R4 late crossing", {vld_cnt, err_cnt}, 1);

    // R4: missing crossing in parity bit
    clr(); gap(80);
    send(10, 1'b1, 16'h0F0F, 1'b0, -1, 0, 16, 99); gap(60);
    chk(vld_cnt == 0 && err_cnt == 1, "R4 missing crossing", {vld_cnt, err_cnt}, 1);

    // R9: back to back, line stays low into data sync
    clr(); gap(80);
    send(10, 1'b1, 16'hC0DE, 1'b0, -1, 0, -1, 99);
    send(10, 1'b0, 16'h0042, 1'b0, -1, 0, -1, 99); gap(60);
    chk(vld_cnt == 2 && err_cnt == 0, "R9 two words", {vld_cnt, err_cnt}, 32'h20000);
    chk(cap_w[0] == 16'hC0DE && cap_c[0] == 1'b1, "R9 first word", {cap_c[0], cap_w[0]}, 17'h1C0DE);
    chk(cap_w[1] == 16'h0042 && cap_c[1] == 1'b0, "R9 second word", {cap_c[1], cap_w[1]}, 17'h00042);

    // R7: idle inside a word, then recovery
    clr(); gap(80);
    send(10, 1'b0, 16'h1357, 1'b0, -1, 0, -1, 5); gap(60);
    chk(vld_cnt == 0 && err_cnt == 1, "R7 idle mid-word", {vld_cnt, err_cnt}, 1);
    clr();
    send(10, 1'b1, 16'h2468, 1'b0, -1, 0, -1, 99); gap(60);
    chk(vld_cnt == 1 && cap_w[0] == 16'h2468, "R7 recovery word", cap_w[0], 16'h2468);

    // R8: one-line mode with rx_neg copying rx_pos
    clk_sel = 2'd2; single_end = 1'b1; neg_eq = 1'b1; clr(); gap(128);
    send(16, 1'b1, 16'h3C5A, 1'b0, -1, 0, -1, 99); gap(96);
    chk(vld_cnt == 1 && cap_w[0] == 16'h3C5A && cap_c[0] == 1'b1, "R8 one-line decode",
        cap_w[0], 16'h3C5A);
    single_end = 1'b0; clr(); gap(128);
    send(16, 1'b1, 16'h3C5A, 1'b0, -1, 0, -1, 99); gap(96);
    chk(vld_cnt == 0 && err_cnt == 0, "R8 same lines read idle in pair mode", {vld_cnt, err_cnt}, 0);
    neg_eq = 1'b0;

    chk(dbl_cnt == 0, "R6 valid one clock", dbl_cnt, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog all-requirements actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule